// File: doc/BRIEF.md
# Elastic Line Buffer with Whole-Line Drop and Repeat

This block is a single-clock elastic byte buffer. It sits between a stream of decoded pixels and the output timing that reads them at its own fixed pace. The writer and the reader may drift apart in rate. The block never stalls either side and never raises an error flag. When the buffer would fill, it throws away the input line being written. When the buffer would run dry, it plays the last complete output line a second time.

A mode input selects how the output frame absorbs the drift. With mode low, every output line keeps its nominal length. The buffer recovers only by dropping or repeating lines, so the number of lines in a frame can change. With mode high, the output timing flags the first byte of the frame's last line. At that byte the read pointer jumps so that the buffer sits exactly half full. The block also reports how long that last line must be to account for the jump. Drop and repeat still act in this mode when the drift is too large for recentering to cover.

The buffer holds `DEPTH` bytes (a power of two). Each output line carries `LINE_LEN` bytes, and `LINE_LEN` must lie between `DEPTH/2` and `DEPTH`. The output timing marks each line start with `rd_sol` and the frame's last line with `rd_last`. Both are meaningful only together with `rd_en`.

Top module: `elastic_line_fifo`

## Requirements
- R1: Bytes written with `wr_en` come out in the order written on `rd_data`, one clock after the `rd_en` cycle that reads them.
- R2: The buffer stores at most `DEPTH-1` bytes. A write made while it already holds `DEPTH-1` bytes is an overflow. Every write below that level is stored.
- R3: On overflow, the write pointer returns to the address where the current input line began, and `drop_pulse` is high for one clock in the next cycle. Writes are then discarded until the next write that carries `wr_sol`, which is stored at the restored address.
- R4: A read attempted while the buffer is empty is an underflow. The read pointer stays put, `rd_data` holds its previous value, and `repeat_pulse` is high for one clock in the next cycle. Later reads without `rd_sol` are ignored and `rd_data` keeps holding.
- R5: At the first `rd_sol` read after an underflow, reading restarts at the start address of the line that underflowed minus `LINE_LEN`. The previous full line is therefore sent again.
- R6: With `mode_fixed_lines` high, a read that carries both `rd_sol` and `rd_last` is taken from the write pointer minus `DEPTH/2`. Reading continues from there, and `recenter_pulse` is high for one clock in the next cycle.
- R7: In the same cycle as `recenter_pulse`, `last_len` becomes `LINE_LEN + occupancy - DEPTH/2`. Here occupancy is the number of bytes stored just before the recentering read. `last_len` holds this value until the next recentering.
- R8: With `mode_fixed_lines` low, `rd_last` has no effect. The read continues from the current pointer, and neither `recenter_pulse` nor `last_len` changes.
- R9: Drop and repeat behave as in R3 to R5 in both modes.
- R10: After reset, `rd_data`, `last_len` and all three pulses are zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fixed_lines | input | 1 | 0: fixed line length; 1: fixed lines per frame with recentering |
| wr_en | input | 1 | Write strobe for one byte |
| wr_sol | input | 1 | This write is the first byte of an input line |
| wr_data | input | DW | Write byte |
| rd_en | input | 1 | Read request for one byte |
| rd_sol | input | 1 | This read is the first byte of an output line |
| rd_last | input | 1 | This output line is the last of the frame (with `rd_sol`) |
| rd_data | output | DW | Read byte, registered |
| drop_pulse | output | 1 | One-clock pulse per dropped input line |
| repeat_pulse | output | 1 | One-clock pulse per underflow |
| recenter_pulse | output | 1 | One-clock pulse per recentering |
| last_len | output | LLW | Length of the recentered last line |

## Verification
The assertions rely on a few conditions on the stimulus. `LINE_LEN` lies between half and all of the buffer. A recentering never falls in the same cycle as an overflow. The writer does not lap the line kept for replay between an underflow and the line start that replays it. The bench meets these conditions with a 64-byte buffer and 40-byte lines. It never writes and reads in the same cycle, and it asserts `rd_last` only with `rd_sol` on a read, so each case's occupancy and expected bytes follow from the stimulus alone.

// File: rtl/elastic_line_fifo.sv
module elastic_line_fifo #(
  parameter int DEPTH    = 2048,
  parameter int LINE_LEN = 1440,
  parameter int DW       = 8,
  localparam int LLW     = $clog2(LINE_LEN + DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_fixed_lines,
  input  logic          wr_en,
  input  logic          wr_sol,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_sol,
  input  logic          rd_last,
  output logic [DW-1:0] rd_data,
  output logic          drop_pulse,
  output logic          repeat_pulse,
  output logic          recenter_pulse,
  output logic [LLW-1:0] last_len
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wls, rls, raddr, occ_w, occ_r;
  logic          dropping, rep_pend;

  assign occ_w = wptr - rptr;

  wire wr_take  = wr_en && (!dropping || wr_sol);
  wire full     = (occ_w == PW'(DEPTH - 1));
  wire do_wr    = wr_take && !full;
  wire ovf      = wr_take && full;

  wire recenter = rd_en && rd_sol && rd_last && mode_fixed_lines;
  wire rewind   = rd_en && rd_sol && rep_pend && !recenter;

  always_comb begin
    if (recenter)    raddr = wptr - PW'(HALF);
    else if (rewind) raddr = rls - PW'(LINE_LEN);
    else             raddr = rptr;
  end

  assign occ_r = wptr - raddr;

  wire rd_try = rd_en && (!rep_pend || rd_sol);
  wire udf    = rd_try && (occ_r == '0);
  wire do_rd  = rd_try && !udf;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      wls      <= '0;
      dropping <= 1'b0;
    end else if (ovf) begin
      wptr     <= wr_sol ? wptr : wls;
      dropping <= 1'b1;
    end else if (do_wr) begin
      wptr <= wptr + 1'b1;
      if (wr_sol) begin
        wls      <= wptr;
        dropping <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr     <= '0;
      rls      <= '0;
      rep_pend <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (rd_en && rd_sol) rls <= raddr;
      if (udf) begin
        rep_pend <= 1'b1;
        rptr     <= raddr;
      end else if (do_rd) begin
        rep_pend <= 1'b0;
        rptr     <= raddr + 1'b1;
        rd_data  <= mem[raddr[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_pulse     <= 1'b0;
      repeat_pulse   <= 1'b0;
      recenter_pulse <= 1'b0;
      last_len       <= '0;
    end else begin
      drop_pulse     <= ovf;
      repeat_pulse   <= udf;
      recenter_pulse <= recenter;
      if (recenter)
        last_len <= LLW'(LINE_LEN) + LLW'(occ_w) - LLW'(HALF);
    end
  end
endmodule

// File: rtl/elastic_line_fifo_chk.sv
module elastic_line_fifo_chk #(
  parameter int DEPTH    = 2048,
  parameter int LINE_LEN = 1440,
  parameter int DW       = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int HALF    = DEPTH / 2,
  localparam int LLW     = $clog2(LINE_LEN + DEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_fixed_lines,
  input logic           wr_en,
  input logic           rd_en,
  input logic           rd_last,
  input logic [DW-1:0]  rd_data,
  input logic           drop_pulse,
  input logic           repeat_pulse,
  input logic           recenter_pulse,
  input logic [LLW-1:0] last_len,
  input logic [PW-1:0]  wptr,
  input logic [PW-1:0]  rptr
);
  wire [PW-1:0] occ = wptr - rptr;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH - 1));

  // R3
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(wr_en));

  // R4
  repeat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_pulse |-> $past(rd_en));

  // R4
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_pulse |-> rd_data == $past(rd_data));

  // R6
  recenter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recenter_pulse |-> $past(mode_fixed_lines) && $past(rd_last));

  // R6
  recenter_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recenter_pulse |-> (occ == PW'(HALF - 1)) || (occ == PW'(HALF)));

  // R7
  last_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recenter_pulse |-> (last_len >= LLW'(LINE_LEN - HALF)) &&
                       (last_len <= LLW'(LINE_LEN + HALF - 1)));
endmodule

bind elastic_line_fifo elastic_line_fifo_chk #(
  .DEPTH(DEPTH), .LINE_LEN(LINE_LEN), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_fixed_lines(mode_fixed_lines),
  .wr_en(wr_en), .rd_en(rd_en), .rd_last(rd_last), .rd_data(rd_data),
  .drop_pulse(drop_pulse), .repeat_pulse(repeat_pulse),
  .recenter_pulse(recenter_pulse), .last_len(last_len),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/elastic_line_fifo_tb_top.sv
`timescale 1ns/1ps
module elastic_line_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int LINE  = 40;
  localparam int LLW   = $clog2(LINE + DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic wr_en = 1'b0, wr_sol = 1'b0, rd_en = 1'b0, rd_sol = 1'b0, rd_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic drop_pulse, repeat_pulse, recenter_pulse;
  logic [LLW-1:0] last_len;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  elastic_line_fifo #(.DEPTH(DEPTH), .LINE_LEN(LINE), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_fixed_lines(mode),
    .wr_en(wr_en), .wr_sol(wr_sol), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sol(rd_sol), .rd_last(rd_last),
    .rd_data(rd_data), .drop_pulse(drop_pulse), .repeat_pulse(repeat_pulse),
    .recenter_pulse(recenter_pulse), .last_len(last_len)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic ws, input logic [7:0] wd,
                     input logic r, input logic rs, input logic rl);
    wr_en = w; wr_sol = ws; wr_data = wd;
    rd_en = r; rd_sol = rs; rd_last = rl;
    @(negedge clk);
    wr_en = 0; wr_sol = 0; rd_en = 0; rd_sol = 0; rd_last = 0;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 0; mode = m;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_line(input int v0, input int n);
    for (int i = 0; i < n; i++) cyc(1, i == 0, 8'(v0 + i), 0, 0, 0);
  endtask

  task automatic rd_line(input string tag, input int v0, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 1, i == 0, 0);
      chk(tag, rd_data, (v0 + i) & 255);
    end
  endtask

  task automatic t_reset;
    do_reset(0);
    chk("R10 rd_data", rd_data, 0);
    chk("R10 drop", drop_pulse, 0);
    chk("R10 repeat", repeat_pulse, 0);
    chk("R10 recenter", recenter_pulse, 0);
    chk("R10 last_len", last_len, 0);
  endtask

  task automatic t_pass;
    do_reset(0);
    wr_line(1, 5);
    rd_line("R1 order", 1, 5);
  endtask

  task automatic t_underflow(input logic m);
    do_reset(m);
    wr_line(0, LINE);
    rd_line("R1 line", 0, LINE);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R4 R9 repeat pulse", repeat_pulse, 1);
    chk("R4 hold", rd_data, LINE - 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R4 single pulse", repeat_pulse, 0);
    chk("R4 hold pending", rd_data, LINE - 1);
    wr_line(50, 10);
    cyc(0, 0, 0, 1, 1, 0);
    chk("R5 replay first", rd_data, 0);
    chk("R5 no pulse", repeat_pulse, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 replay second", rd_data, 1);
  endtask

  task automatic t_overflow(input logic m);
    do_reset(m);
    wr_line(0, LINE);
    for (int i = 0; i < 30; i++) begin
      cyc(1, i == 0, 8'(100 + i), 0, 0, 0);
      if (i == 22) chk("R2 fill to DEPTH-1", drop_pulse, 0);
      if (i == 23) chk("R3 R9 drop pulse", drop_pulse, 1);
      if (i == 24) chk("R3 single pulse", drop_pulse, 0);
    end
    wr_line(200, 10);
    rd_line("R3 line kept", 0, LINE);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R3 dropped line gone", rd_data, 200);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R3 next line", rd_data, 201);
  endtask

  task automatic t_recenter_high;
    do_reset(1);
    wr_line(0, 50);
    cyc(0, 0, 0, 1, 1, 1);
    chk("R6 jump data", rd_data, 50 - DEPTH / 2);
    chk("R6 pulse", recenter_pulse, 1);
    chk("R7 last_len", last_len, LINE + 50 - DEPTH / 2);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 continue", rd_data, 50 - DEPTH / 2 + 1);
    chk("R6 single pulse", recenter_pulse, 0);
    chk("R7 hold", last_len, LINE + 50 - DEPTH / 2);
  endtask

  task automatic t_recenter_low;
    do_reset(1);
    wr_line(0, 45);
    rd_line("R1 before recenter", 0, LINE);
    wr_line(45, 3);
    cyc(0, 0, 0, 1, 1, 1);
    chk("R6 jump back data", rd_data, 48 - DEPTH / 2);
    chk("R7 short last line", last_len, LINE + 8 - DEPTH / 2);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 continue back", rd_data, 48 - DEPTH / 2 + 1);
  endtask

  task automatic t_mode0_last;
    do_reset(0);
    wr_line(0, 50);
    cyc(0, 0, 0, 1, 1, 1);
    chk("R8 data", rd_data, 0);
    chk("R8 no pulse", recenter_pulse, 0);
    chk("R8 last_len", last_len, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 continue", rd_data, 1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_underflow(0);
    t_underflow(1);
    t_overflow(0);
    t_overflow(1);
    t_recenter_high();
    t_recenter_low();
    t_mode0_last();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule